// File: doc/BRIEF.md
# Programmable Joystick Keymap Injector

This block holds a programmable key map for a bank of joystick inputs. It merges the joystick inputs that are currently pressed into the row response of a keyboard matrix. Each joystick input has two map bytes. One is a column mask that is compared against the upper address byte of a keyboard read. The other is a row mask that names the key rows the input reports as pressed.

Software programs the map with ordinary memory writes while a write-enable code sits in the upper nibble of a control register. Only the low address bits pick the map byte, so these writes land in the map and also in whatever memory the address decodes to. The real keyboard scan and debouncing are outside this block: it takes the scanned rows in and returns them with the joystick keys added.

Top module: `jk_injector`

## Requirements
- R1: A memory write changes the map only when bits 7:4 of `ctrl_reg` equal 4'b1011. Writes under any other value of that nibble leave the map untouched.
- R2: Only address bits 4:0 of `mem_addr` select the map byte. Upper address bits and the lower nibble of `ctrl_reg` have no effect.
- R3: Map byte 2k is the column mask of joystick input k (`joy[k]`). Bit b of that mask corresponds to keyboard-read address bit 8+b, which is bit b of `kb_addr_hi`.
- R4: Map byte 2k+1 keeps data bits 4:0 as the row mask of input k. Bit r set means row r is reported pressed. Data bits 7:5 are discarded.
- R5: On a keyboard read, input k adds its row mask to the pressed set only when `joy[k]` is 1 and (column mask AND NOT `kb_addr_hi`) is non-zero. A column is addressed when its address bit is 0.
- R6: One cycle after a cycle with `kb_rd` high, `key_rows` equals `matrix_rows` AND NOT the pressed set. Rows are active-low, and 0 means pressed.
- R7: `key_rows` holds its value in every cycle that follows a cycle without `kb_rd`.
- R8: Synchronous reset clears every map byte and sets `key_rows` to 5'h1F. Until the map is programmed, no input injects a key.
- R9: When a map write and a keyboard read fall in the same cycle, the read uses the map as it stood before that write.
- R10: When several inputs qualify at once, their row masks are ORed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_reg | input | 8 | Control register value; bits 7:4 carry the map write-enable code |
| mem_wr | input | 1 | CPU memory write strobe, one cycle per write |
| mem_addr | input | ADDR_W | CPU memory write address |
| mem_wdata | input | 8 | CPU memory write data |
| kb_rd | input | 1 | Keyboard port read strobe |
| kb_addr_hi | input | 8 | Address bits 15:8 of the keyboard read |
| joy | input | NUM_INPUTS | Debounced joystick lines, 1 = pressed |
| matrix_rows | input | ROW_W | Scanned keyboard rows, active-low |
| key_rows | output | ROW_W | Merged key rows, active-low, registered |

## Verification
The bench builds the block with its default parameters: 16 inputs, 8 column bits, 5 rows and a 16-bit address. With these values the map index spans all 32 bytes, including the last row byte at address 31. The bench also puts non-zero upper address bits in front of the 5-bit decode. Because the column mask is as wide as the whole upper address byte, every single-column read and every mask bit position can be reached. The top input, 15, shares a column with a low input to exercise the OR of row masks.

// File: rtl/jk_pkg.sv
package jk_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] MAP_WR_CODE = 4'b1011;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/jk_wr_decode.sv
module jk_wr_decode
  import jk_pkg::*;
#(
  parameter int NUM_INPUTS = 16,
  parameter int ADDR_W     = 16,
  localparam int IDX_W     = $clog2(2 * NUM_INPUTS)
) (
  input  logic                  mem_wr,
  input  byte_t                 ctrl_reg,
  input  logic [ADDR_W-1:0]     mem_addr,
  output logic                  wr_hit,
  output logic [NUM_INPUTS-1:0] col_we,
  output logic [NUM_INPUTS-1:0] row_we
);
  logic [IDX_W-1:0] idx;

  assign idx    = mem_addr[IDX_W-1:0];
  assign wr_hit = mem_wr && (ctrl_reg[7:4] == MAP_WR_CODE);

  for (genvar k = 0; k < NUM_INPUTS; k++) begin : g_we
    localparam logic [IDX_W-2:0] SLOT = (IDX_W-1)'(k);
    assign col_we[k] = wr_hit && (idx[IDX_W-1:1] == SLOT) && !idx[0];
    assign row_we[k] = wr_hit && (idx[IDX_W-1:1] == SLOT) &&  idx[0];
  end
endmodule

// File: rtl/jk_map_store.sv
module jk_map_store
  import jk_pkg::*;
#(
  parameter int NUM_INPUTS = 16,
  parameter int ROW_W      = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_INPUTS-1:0]            col_we,
  input  logic [NUM_INPUTS-1:0]            row_we,
  input  byte_t                            wdata,
  output logic [NUM_INPUTS-1:0][BYTE_W-1:0] col_map,
  output logic [NUM_INPUTS-1:0][ROW_W-1:0]  row_map
);
  for (genvar k = 0; k < NUM_INPUTS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        col_map[k] <= '0;
        row_map[k] <= '0;
      end else begin
        if (col_we[k]) col_map[k] <= wdata;
        if (row_we[k]) row_map[k] <= wdata[ROW_W-1:0];
      end
    end
  end
endmodule

// File: rtl/jk_merge.sv
module jk_merge
  import jk_pkg::*;
#(
  parameter int NUM_INPUTS = 16,
  parameter int ROW_W      = 5
) (
  input  logic [NUM_INPUTS-1:0]             joy,
  input  byte_t                             kb_addr_hi,
  input  logic [NUM_INPUTS-1:0][BYTE_W-1:0] col_map,
  input  logic [NUM_INPUTS-1:0][ROW_W-1:0]  row_map,
  output logic [ROW_W-1:0]                  pressed
);
  logic [NUM_INPUTS-1:0][ROW_W-1:0] contrib;

  for (genvar k = 0; k < NUM_INPUTS; k++) begin : g_in
    logic hit;
    assign hit        = joy[k] && (|(col_map[k] & ~kb_addr_hi));
    assign contrib[k] = hit ? row_map[k] : '0;
  end

  always_comb begin
    pressed = '0;
    for (int k = 0; k < NUM_INPUTS; k++) pressed = pressed | contrib[k];
  end
endmodule

// File: rtl/jk_injector.sv
module jk_injector
  import jk_pkg::*;
#(
  parameter int NUM_INPUTS = 16,
  parameter int ROW_W      = 5,
  parameter int ADDR_W     = 16,
  localparam int IDX_W     = $clog2(2 * NUM_INPUTS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [7:0]            ctrl_reg,
  input  logic                  mem_wr,
  input  logic [ADDR_W-1:0]     mem_addr,
  input  logic [7:0]            mem_wdata,
  input  logic                  kb_rd,
  input  logic [7:0]            kb_addr_hi,
  input  logic [NUM_INPUTS-1:0] joy,
  input  logic [ROW_W-1:0]      matrix_rows,
  output logic [ROW_W-1:0]      key_rows
);
  logic                             wr_hit;
  logic [NUM_INPUTS-1:0]            col_we;
  logic [NUM_INPUTS-1:0]            row_we;
  logic [NUM_INPUTS-1:0][BYTE_W-1:0] col_map;
  logic [NUM_INPUTS-1:0][ROW_W-1:0]  row_map;
  logic [ROW_W-1:0]                 pressed;

  jk_wr_decode #(.NUM_INPUTS(NUM_INPUTS), .ADDR_W(ADDR_W)) u_dec (
    .mem_wr(mem_wr), .ctrl_reg(ctrl_reg), .mem_addr(mem_addr),
    .wr_hit(wr_hit), .col_we(col_we), .row_we(row_we)
  );

  jk_map_store #(.NUM_INPUTS(NUM_INPUTS), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst(rst), .col_we(col_we), .row_we(row_we),
    .wdata(mem_wdata), .col_map(col_map), .row_map(row_map)
  );

  jk_merge #(.NUM_INPUTS(NUM_INPUTS), .ROW_W(ROW_W)) u_merge (
    .joy(joy), .kb_addr_hi(kb_addr_hi), .col_map(col_map),
    .row_map(row_map), .pressed(pressed)
  );

  always_ff @(posedge clk) begin
    if (rst)        key_rows <= '1;
    else if (kb_rd) key_rows <= matrix_rows & ~pressed;
  end

  initial begin
    assert (ADDR_W >= IDX_W && ROW_W <= BYTE_W)
      else $error("jk_injector: parameter set out of range");
  end

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && ctrl_reg[7:4] != MAP_WR_CODE) |=> ($stable(col_map) && $stable(row_map))); // R1

  AST_COL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !mem_addr[0]) |=> col_map[$past(mem_addr[IDX_W-1:1])] == $past(mem_wdata)); // R3

  AST_ROW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && mem_addr[0]) |=> row_map[$past(mem_addr[IDX_W-1:1])] == $past(mem_wdata[ROW_W-1:0])); // R4

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (kb_rd && joy == '0) |=> key_rows == $past(matrix_rows)); // R5

  AST_NO_FALSE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    kb_rd |=> (key_rows & ~$past(matrix_rows)) == '0); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !kb_rd |=> $stable(key_rows)); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (col_map == '0 && row_map == '0 && key_rows == '1)); // R8
endmodule

// File: tb/test_jk_injector.sv
module test_jk_injector;
  localparam int N  = 16;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    ctrl_reg = 8'h00;
  logic          mem_wr = 1'b0;
  logic [15:0]   mem_addr = '0;
  logic [7:0]    mem_wdata = '0;
  logic          kb_rd = 1'b0;
  logic [7:0]    kb_addr_hi = 8'hFF;
  logic [N-1:0]  joy = '0;
  logic [RW-1:0] matrix_rows = 5'h1F;
  logic [RW-1:0] key_rows;

  int checks = 0;
  int errors = 0;
  int colm[N];
  int rowm[N];
  int exp_rows = 31;
  string tag = "R8";

  jk_injector i_jk_injector (
    .clk(clk), .rst(rst), .ctrl_reg(ctrl_reg), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .kb_rd(kb_rd),
    .kb_addr_hi(kb_addr_hi), .joy(joy), .matrix_rows(matrix_rows),
    .key_rows(key_rows)
  );

  always #10 clk = ~clk;

  function automatic int model_pressed();
    int p = 0;
    for (int k = 0; k < N; k++)
      if (joy[k] && ((colm[k] & ~int'(kb_addr_hi) & 255) != 0)) p = p | rowm[k];
    return p;
  endfunction

  task automatic check(string req, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s: key_rows=%h expected=%h at %0t", req, got, expv, $time);
    end
  endtask

  // one clock: model follows the posedge, output compared at the negedge
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      exp_rows = 31;
      for (int k = 0; k < N; k++) begin colm[k] = 0; rowm[k] = 0; end
    end else begin
      if (kb_rd) exp_rows = int'(matrix_rows) & ~model_pressed() & 31;
      if (mem_wr && ctrl_reg[7:4] == 4'b1011) begin
        int i = int'(mem_addr) % 32;
        if (i % 2 == 0) colm[i/2] = int'(mem_wdata);
        else            rowm[i/2] = int'(mem_wdata) & 31;
      end
    end
    @(negedge clk);
    check(tag, int'(key_rows), exp_rows);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
    tick();
    mem_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] hi);
    kb_rd = 1'b1; kb_addr_hi = hi;
    tick();
    kb_rd = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R8";
    repeat (3) tick();
    rst = 1'b0;
    check("R8", int'(key_rows), 31);
    joy = '1;
    rd(8'h00);
    check("R8", int'(key_rows), 5'h1F);

    tag = "R1";
    ctrl_reg = 8'hA0;
    wr(16'h0000, 8'hFF);
    wr(16'h0001, 8'h1F);
    ctrl_reg = 8'h3B;
    wr(16'h0000, 8'hFF);
    wr(16'h0001, 8'h1F);
    rd(8'h00);
    check("R1", int'(key_rows), 5'h1F);

    tag = "R2";
    joy = '0;
    ctrl_reg = 8'hB5;
    wr(16'hC3E0, 8'h01);
    wr(16'h7F21, 8'h01);
    joy[0] = 1'b1;
    rd(8'hFE);
    check("R2", int'(key_rows), 5'h1E);

    tag = "R5";
    rd(8'hFD);
    check("R5", int'(key_rows), 5'h1F);
    joy[0] = 1'b0;
    rd(8'hFE);
    check("R5", int'(key_rows), 5'h1F);

    tag = "R4";
    wr(16'h0002, 8'h80);
    wr(16'h0003, 8'hFF);
    joy[1] = 1'b1;
    rd(8'h7F);
    check("R4", int'(key_rows), 5'h00);

    tag = "R3";
    wr(16'h0004, 8'h02);
    wr(16'h0005, 8'h04);
    wr(16'h001E, 8'h02);
    wr(16'h001F, 8'hF0);
    joy = '0;
    joy[15] = 1'b1;
    rd(8'hFD);
    check("R3", int'(key_rows), 5'h0F);

    tag = "R10";
    joy[2] = 1'b1;
    matrix_rows = 5'h1E;
    rd(8'hFD);
    check("R10", int'(key_rows), 5'h0A);

    tag = "R6";
    matrix_rows = 5'h15;
    joy = '0;
    rd(8'h00);
    check("R6", int'(key_rows), 5'h15);

    tag = "R7";
    matrix_rows = 5'h00;
    joy = '1;
    kb_addr_hi = 8'h00;
    repeat (4) tick();
    check("R7", int'(key_rows), 5'h15);

    tag = "R9";
    matrix_rows = 5'h1F;
    joy = '0;
    joy[3] = 1'b1;
    wr(16'h0006, 8'h10);
    mem_wr = 1'b1; mem_addr = 16'h0007; mem_wdata = 8'h08;
    kb_rd = 1'b1; kb_addr_hi = 8'hEF;
    tick();
    mem_wr = 1'b0; kb_rd = 1'b0;
    check("R9", int'(key_rows), 5'h1F);
    rd(8'hEF);
    check("R9", int'(key_rows), 5'h17);

    tag = "R8";
    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R8", int'(key_rows), 5'h1F);
    joy = '1;
    rd(8'h00);
    check("R8", int'(key_rows), 5'h1F);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule